// File: doc/BRIEF.md
# PLL Power and Lock Sequencer

This block sequences the analog power-down and the output clock gate of a single phase-locked loop. It has two operating modes. With the hardware-mode input low, software owns the loop directly: its power-down and clock-enable bits pass straight to the analog macro, and software must raise the gate only after lock and drop it before powering down. With the hardware-mode input high, a system-level enable request runs the loop through a state machine. The machine has six states: OFF, POWER_UP, WAIT_LOCK, RUN, CHG_PD and CHG_UPDATE. The loop is powered up, and the clock is released only after a lock-wait window has expired and the synchronized lock indication is high.

In hardware mode with change mode active, a software write of a new feedback-divider or fraction value is held as pending. Once the machine is in RUN, it walks through RUN -> CHG_PD -> CHG_UPDATE -> POWER_UP -> WAIT_LOCK -> RUN. It powers the loop down, applies the held value, powers up and relocks. The response bit returned to the system controller stays high through that whole walk. The named transitions are as follows:
- OFF -> POWER_UP when enabled.
- POWER_UP -> WAIT_LOCK unconditionally.
- WAIT_LOCK -> RUN on an expired counter with lock.
- RUN -> CHG_PD on a pending parameter.
- CHG_PD -> CHG_UPDATE unconditionally.
- CHG_UPDATE -> POWER_UP unconditionally.
- Any state -> OFF when the delayed enable or the hardware mode is low.

The lock wait is counted on the reference clock. A zero configuration selects a default of 1500 cycles times the reference divide. The analog loop and its lock detector are outside the block and appear only as inputs and outputs.

Top module: `pll_seq_top`

## Requirements
- R1: While reset is asserted, the response is 0 and the applied divider and fraction equal their reset parameters (40 and 0). In hardware mode with the system enable low, power-down is 1 and the clock gate is 0.
- R2: With the hardware-mode input low, power-down equals the software power-down input and the clock gate equals the software clock-enable input in the same cycle, and the state machine is held in OFF.
- R3: With the hardware-mode input high, power-down is 1 exactly when the system enable delayed by one flop is 0, or the state is OFF, CHG_PD or CHG_UPDATE.
- R4: With the hardware-mode input high, the clock gate is 1 exactly when the state is RUN, the synchronized lock is 1 and the delayed enable is 1.
- R5: The raw lock output equals the lock input. The synchronized lock output is the lock input delayed by two flops.
- R6: POWER_UP lasts one cycle and loads the lock counter with N. WAIT_LOCK decrements the counter once per cycle down to 0, and moves to RUN on the first edge where the counter is 0 and the synchronized lock is 1. With lock already high, the response rises N+4 clock edges after the system enable rises. The counter is reloaded on every power-up.
- R7: A lock-count configuration of 0 selects N = 1500 times the reference divide, and a reference divide of 0 counts as 1.
- R8: In hardware mode with change mode high, a parameter write in any state except OFF is held as pending and leaves the applied values unchanged. From RUN a pending value causes CHG_PD, then CHG_UPDATE, which applies it on its exit edge, then POWER_UP.
- R9: A parameter write when hardware mode or change mode is low, or when the state is OFF, updates the applied values on the next edge.
- R10: The response is set on the edge entering RUN, cleared on the edge entering OFF, and otherwise held, so it stays 1 throughout a change sequence.
- R11: The powered-off output is 1 exactly when the system enable input and the response are both 0.
- R12: From any state other than OFF, a low delayed enable or a low hardware-mode input moves the machine to OFF on the next edge.
- R13: A parameter write landing in the CHG_UPDATE cycle leaves the earlier pending value to be applied and keeps the new one pending, so a second change sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode_i | input | 1 | 1: state machine drives the loop; 0: software bits drive it |
| sw_pd_i | input | 1 | Software power-down bit |
| sw_clken_i | input | 1 | Software clock-enable bit |
| sys_en_i | input | 1 | System-level enable request |
| chg_mode_i | input | 1 | Enables automatic change sequences on parameter writes |
| param_wr_i | input | 1 | One-cycle write strobe for divider and fraction |
| param_fbdiv_i | input | 12 | Written feedback divider |
| param_frac_i | input | 24 | Written fraction |
| lock_cnt_cfg_i | input | 20 | Lock-wait count; 0 selects the default |
| ref_div_i | input | 6 | Reference divide used for the default count |
| pll_lock_i | input | 1 | Raw lock from the analog detector |
| pll_pd_o | output | 1 | Analog power-down |
| pll_clken_o | output | 1 | Output clock-gate enable |
| pll_fbdiv_o | output | 12 | Applied feedback divider |
| pll_frac_o | output | 24 | Applied fraction |
| sys_resp_o | output | 1 | Response to the system controller |
| pll_off_o | output | 1 | Loop counts as powered off |
| lock_raw_o | output | 1 | Raw lock status |
| lock_sync_o | output | 1 | Synchronized lock status |

## Verification
Two collisions are driven on purpose. In the first, a second parameter write is timed to land on the very cycle the machine leaves CHG_UPDATE, so the apply of the old pending value and the capture of the new one happen together. In the second, the system enable is dropped while the machine sits in CHG_PD, so the abort to OFF competes with the change walk. The bench times both from its own behavioural model's phase. It then compares power-down, clock gate, response and applied values on every cycle, so one cycle of wrong priority shows up as a mismatch.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_POWER_UP   = 3'd1,
        ST_WAIT_LOCK  = 3'd2,
        ST_RUN        = 3'd3,
        ST_CHG_PD     = 3'd4,
        ST_CHG_UPDATE = 3'd5
    } seq_state_e;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int CNT_W    = 20,
    parameter int DIV_W    = 6,
    parameter int DEF_BASE = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cfg_i,
    input  logic [DIV_W-1:0] ref_div_i,
    output logic             done_o
);
    localparam int PROD_W = CNT_W + DIV_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [DIV_W-1:0]  eff_div;
    logic [PROD_W-1:0] def_full;
    logic [CNT_W-1:0]  load_val;

    always_comb begin
        eff_div  = (ref_div_i == '0) ? DIV_W'(1) : ref_div_i;
        def_full = PROD_W'(DEF_BASE) * PROD_W'(eff_div);
        load_val = (cfg_i == '0) ? def_full[CNT_W-1:0] : cfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load_i)                  cnt_q <= load_val;
        else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done_o = (cnt_q == '0);

    // R6: an expired counter stays expired until the next power-up reload
    p_cnt_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_mode_i,
    input  logic       en_d_i,
    input  logic       lock_ok_i,
    input  logic       cnt_done_i,
    input  logic       pend_i,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       count_o,
    output logic       apply_o,
    output logic       chg_pd_o,
    output logic       run_o,
    output logic       resp_o
);
    seq_state_e state_q, state_d;
    logic       resp_q;

    always_comb begin
        state_d = state_q;
        if (!hw_mode_i || !en_d_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:        state_d = ST_POWER_UP;
                ST_POWER_UP:   state_d = ST_WAIT_LOCK;
                ST_WAIT_LOCK:  state_d = (cnt_done_i && lock_ok_i) ? ST_RUN : ST_WAIT_LOCK;
                ST_RUN:        state_d = pend_i ? ST_CHG_PD : ST_RUN;
                ST_CHG_PD:     state_d = ST_CHG_UPDATE;
                ST_CHG_UPDATE: state_d = ST_POWER_UP;
                default:       state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  resp_q <= 1'b0;
        else if (state_d == ST_RUN)  resp_q <= 1'b1;
        else if (state_d == ST_OFF)  resp_q <= 1'b0;
    end

    always_comb begin
        load_o   = 1'b0;
        count_o  = 1'b0;
        apply_o  = 1'b0;
        chg_pd_o = 1'b0;
        run_o    = 1'b0;
        unique case (state_q)
            ST_OFF:        chg_pd_o = 1'b1;
            ST_POWER_UP:   load_o   = 1'b1;
            ST_WAIT_LOCK:  count_o  = 1'b1;
            ST_RUN:        run_o    = 1'b1;
            ST_CHG_PD:     chg_pd_o = 1'b1;
            ST_CHG_UPDATE: begin
                chg_pd_o = 1'b1;
                apply_o  = 1'b1;
            end
            default:       chg_pd_o = 1'b1;
        endcase
    end

    assign state_o = state_q;
    assign resp_o  = resp_q;

    // R8: power-down step of a change walk is followed by the update step or an abort
    p_chg_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHG_PD) |=> (state_q == ST_CHG_UPDATE || state_q == ST_OFF));

    // R10: the response is never dropped inside a change walk
    p_resp_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHG_PD || state_q == ST_CHG_UPDATE) |-> resp_q);

    // R6: no entry into RUN while the lock window is still open
    p_wait_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LOCK && !cnt_done_i) |=> (state_q != ST_RUN));

    // R12: losing the delayed enable always ends in OFF
    p_drop_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && !en_d_i) |=> (state_q == ST_OFF));

endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
    import pll_seq_pkg::*;
#(
    parameter int             FBDIV_W       = 12,
    parameter int             FRAC_W        = 24,
    parameter int             CNT_W         = 20,
    parameter int             DIV_W         = 6,
    parameter int             DEF_LOCK_BASE = 1500,
    parameter int             SYNC_STAGES   = 2,
    parameter logic [11:0]    FBDIV_RST     = 12'd40,
    parameter logic [23:0]    FRAC_RST      = 24'd0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_mode_i,
    input  logic               sw_pd_i,
    input  logic               sw_clken_i,
    input  logic               sys_en_i,
    input  logic               chg_mode_i,
    input  logic               param_wr_i,
    input  logic [FBDIV_W-1:0] param_fbdiv_i,
    input  logic [FRAC_W-1:0]  param_frac_i,
    input  logic [CNT_W-1:0]   lock_cnt_cfg_i,
    input  logic [DIV_W-1:0]   ref_div_i,
    input  logic               pll_lock_i,
    output logic               pll_pd_o,
    output logic               pll_clken_o,
    output logic [FBDIV_W-1:0] pll_fbdiv_o,
    output logic [FRAC_W-1:0]  pll_frac_o,
    output logic               sys_resp_o,
    output logic               pll_off_o,
    output logic               lock_raw_o,
    output logic               lock_sync_o
);
    seq_state_e         state;
    logic               en_d_q;
    logic               lock_s;
    logic               cnt_done;
    logic               load, count, apply, chg_pd, run_st, resp;
    logic               pend_q;
    logic [FBDIV_W-1:0] pend_fbdiv_q, fbdiv_q;
    logic [FRAC_W-1:0]  pend_frac_q, frac_q;
    logic               wr_defer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_d_q <= 1'b0;
        else        en_d_q <= sys_en_i;
    end

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pll_lock_i),
        .q_o   (lock_s)
    );

    pll_lock_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DEF_BASE(DEF_LOCK_BASE)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .run_i     (count),
        .cfg_i     (lock_cnt_cfg_i),
        .ref_div_i (ref_div_i),
        .done_o    (cnt_done)
    );

    pll_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_mode_i  (hw_mode_i),
        .en_d_i     (en_d_q),
        .lock_ok_i  (lock_s),
        .cnt_done_i (cnt_done),
        .pend_i     (pend_q),
        .state_o    (state),
        .load_o     (load),
        .count_o    (count),
        .apply_o    (apply),
        .chg_pd_o   (chg_pd),
        .run_o      (run_st),
        .resp_o     (resp)
    );

    assign wr_defer = param_wr_i && hw_mode_i && chg_mode_i && (state != ST_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fbdiv_q <= FBDIV_RST[FBDIV_W-1:0];
            frac_q  <= FRAC_RST[FRAC_W-1:0];
        end else if (param_wr_i && !wr_defer) begin
            fbdiv_q <= param_fbdiv_i;
            frac_q  <= param_frac_i;
        end else if (apply) begin
            fbdiv_q <= pend_fbdiv_q;
            frac_q  <= pend_frac_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_fbdiv_q <= '0;
            pend_frac_q  <= '0;
        end else if (wr_defer) begin
            pend_q       <= 1'b1;
            pend_fbdiv_q <= param_fbdiv_i;
            pend_frac_q  <= param_frac_i;
        end else if (apply) begin
            pend_q       <= 1'b0;
        end
    end

    always_comb begin
        if (hw_mode_i) begin
            pll_pd_o    = !en_d_q || chg_pd;
            pll_clken_o = run_st && lock_s && en_d_q;
        end else begin
            pll_pd_o    = sw_pd_i;
            pll_clken_o = sw_clken_i;
        end
    end

    assign pll_fbdiv_o = fbdiv_q;
    assign pll_frac_o  = frac_q;
    assign sys_resp_o  = resp;
    assign pll_off_o   = !sys_en_i && !resp;
    assign lock_raw_o  = pll_lock_i;
    assign lock_sync_o = lock_s;

    // R4: in hardware mode the gate opens only in RUN
    p_gate_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode_i && pll_clken_o) |-> (state == ST_RUN));

    // R3: in hardware mode the loop is held down while OFF
    p_pd_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode_i && state == ST_OFF) |-> pll_pd_o);

    // R8: a deferred write does not touch the applied divider on the next edge
    p_defer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_defer && !apply) |=> $stable(pll_fbdiv_o));

endmodule

// File: tb/tb_pll_seq_top.sv
`timescale 1ns/1ps
module tb_pll_seq_top;
    localparam int FB_W = 12;
    localparam int FR_W = 24;
    localparam int C_W  = 20;
    localparam int D_W  = 6;
    localparam int FB_RST = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_mode = 1'b1, sw_pd = 1'b1, sw_clken = 1'b0, sys_en = 1'b0;
    logic chg_mode = 1'b0, wr = 1'b0, lock = 1'b0;
    logic [FB_W-1:0] wfb = '0;
    logic [FR_W-1:0] wfr = '0;
    logic [C_W-1:0]  cfg = 20'd5;
    logic [D_W-1:0]  rdiv = 6'd1;
    logic pd, clken, resp, off, lraw, lsync;
    logic [FB_W-1:0] fb;
    logic [FR_W-1:0] fr;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pll_seq_top dut (
        .clk(clk), .rst_n(rst_n), .hw_mode_i(hw_mode), .sw_pd_i(sw_pd),
        .sw_clken_i(sw_clken), .sys_en_i(sys_en), .chg_mode_i(chg_mode),
        .param_wr_i(wr), .param_fbdiv_i(wfb), .param_frac_i(wfr),
        .lock_cnt_cfg_i(cfg), .ref_div_i(rdiv), .pll_lock_i(lock),
        .pll_pd_o(pd), .pll_clken_o(clken), .pll_fbdiv_o(fb), .pll_frac_o(fr),
        .sys_resp_o(resp), .pll_off_o(off), .lock_raw_o(lraw), .lock_sync_o(lsync)
    );

    // Behavioural reference: phase 0 off, 1 power-up, 2 wait, 3 run, 4 change-down, 5 update
    int m_ph = 0, m_cnt = 0;
    bit m_resp = 0, m_pend = 0, m_s1 = 0, m_s2 = 0, m_en = 0;
    int m_af = FB_RST, m_aq = 0, m_pf = 0, m_pq = 0;

    always @(posedge clk) begin
        int nx, lv, dv;
        bit defer;
        if (!rst_n) begin
            m_ph <= 0; m_cnt <= 0; m_resp <= 0; m_pend <= 0; m_s1 <= 0; m_s2 <= 0;
            m_en <= 0; m_af <= FB_RST; m_aq <= 0; m_pf <= 0; m_pq <= 0;
        end else begin
            defer = wr && hw_mode && chg_mode && (m_ph != 0);
            if (!hw_mode || !m_en) nx = 0;
            else if (m_ph == 0) nx = 1;
            else if (m_ph == 1) nx = 2;
            else if (m_ph == 2) nx = (m_cnt == 0 && m_s2) ? 3 : 2;
            else if (m_ph == 3) nx = m_pend ? 4 : 3;
            else if (m_ph == 4) nx = 5;
            else nx = 1;
            dv = (rdiv == 0) ? 1 : int'(rdiv);
            lv = (cfg == 0) ? 1500 * dv : int'(cfg);
            if (m_ph == 1) m_cnt <= lv;
            else if (m_ph == 2 && m_cnt > 0) m_cnt <= m_cnt - 1;
            if (nx == 3) m_resp <= 1; else if (nx == 0) m_resp <= 0;
            if (wr && !defer) begin m_af <= int'(wfb); m_aq <= int'(wfr); end
            else if (m_ph == 5) begin m_af <= m_pf; m_aq <= m_pq; end
            if (defer) begin m_pend <= 1; m_pf <= int'(wfb); m_pq <= int'(wfr); end
            else if (m_ph == 5) m_pend <= 0;
            m_s1 <= lock; m_s2 <= m_s1; m_en <= sys_en; m_ph <= nx;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit e_pd, e_ck;
        if (hw_mode) begin
            e_pd = !m_en || m_ph == 0 || m_ph == 4 || m_ph == 5;
            e_ck = (m_ph == 3) && m_s2 && m_en;
            chk("R3", "pd", 64'(pd), 64'(e_pd));
            chk("R4", "clken", 64'(clken), 64'(e_ck));
        end else begin
            chk("R2", "pd", 64'(pd), 64'(sw_pd));
            chk("R2", "clken", 64'(clken), 64'(sw_clken));
        end
        chk("R10", "resp", 64'(resp), 64'(m_resp));
        chk("R11", "off", 64'(off), 64'(!sys_en && !m_resp));
        chk("R5", "lock_raw", 64'(lraw), 64'(lock));
        chk("R5", "lock_sync", 64'(lsync), 64'(m_s2));
        chk("R8", "fbdiv", 64'(fb), 64'(m_af));
        chk("R9", "frac", 64'(fr), 64'(m_aq));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_par(input int f, input int q);
        wr = 1'b1; wfb = FB_W'(f); wfr = FR_W'(q);
        step();
        wr = 1'b0;
    endtask

    task automatic wait_phase(input int p);
        for (int i = 0; i < 5000 && m_ph != p; i++) step();
    endtask

    task automatic edges_to_resp(input int lim, output int n);
        n = 0;
        while (!resp && n < lim) begin step(); n++; end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int n;
        @(posedge clk); @(negedge clk);
        // R1: reset values
        chk("R1", "pd in reset", 64'(pd), 64'd1);
        chk("R1", "clken in reset", 64'(clken), 64'd0);
        chk("R1", "resp in reset", 64'(resp), 64'd0);
        chk("R1", "fbdiv in reset", 64'(fb), 64'(FB_RST));
        chk("R1", "frac in reset", 64'(fr), 64'd0);
        steps(2);
        rst_n = 1'b1;
        steps(2);

        // R2 / R9: software mode
        hw_mode = 1'b0;
        sw_pd = 1'b0; step();
        sw_clken = 1'b1; step();
        write_par(55, 24'h800000); step();
        chk("R9", "direct write applied", 64'(fb), 64'd55);
        sw_clken = 1'b0; step();
        sw_pd = 1'b1; step();
        sys_en = 1'b1; steps(4);
        chk("R2", "resp stays low in software mode", 64'(resp), 64'd0);
        sys_en = 1'b0; steps(2);

        // R6: hardware mode bring-up, cfg 5, lock already high
        hw_mode = 1'b1; lock = 1'b1; cfg = 20'd5; steps(4);
        sys_en = 1'b1;
        edges_to_resp(100, n);
        chk("R6", "edges to response", 64'(n), 64'd9);
        steps(5);
        lock = 1'b0; steps(4);
        lock = 1'b1; steps(4);

        // R8 / R10: change walk with lock lost during relock
        chg_mode = 1'b1;
        write_par(60, 24'h200000);
        chk("R8", "deferred write not applied", 64'(fb), 64'd55);
        wait_phase(1);
        lock = 1'b0; steps(6);
        lock = 1'b1;
        wait_phase(3); steps(3);
        chk("R8", "pending applied after walk", 64'(fb), 64'd60);
        chk("R10", "response high after walk", 64'(resp), 64'd1);

        // R13: second write lands in the update cycle
        write_par(70, 24'h1);
        wait_phase(5);
        write_par(80, 24'h2);
        wait_phase(3); steps(2);
        wait_phase(4);
        wait_phase(3); steps(3);
        chk("R13", "second pending applied", 64'(fb), 64'd80);

        // R12: enable dropped while powering down for a change
        write_par(90, 24'h3);
        wait_phase(4);
        sys_en = 1'b0; steps(4);
        chk("R12", "aborted to off", 64'(resp), 64'd0);
        write_par(91, 24'h4); step();
        chk("R9", "write in off applied", 64'(fb), 64'd91);

        // R7: default window, divide 0 treated as 1
        cfg = '0; rdiv = 6'd0; steps(2);
        sys_en = 1'b1;
        edges_to_resp(3000, n);
        chk("R7", "default edges to response", 64'(n), 64'd1504);
        // R9: change mode off, write in RUN applies directly
        chg_mode = 1'b0;
        write_par(100, 24'h5); step();
        chk("R9", "direct write in run", 64'(fb), 64'd100);
        rdiv = 6'd2; chg_mode = 1'b1;
        write_par(101, 24'h6);
        wait_phase(3); steps(3);
        // R12: hardware mode dropped from RUN
        hw_mode = 1'b0; steps(3);
        hw_mode = 1'b1; steps(8);
        summary();
        $finish;
    end
endmodule